// File: doc/BRIEF.md
# Uniformly-Switching One-Bit Adder

This block adds three single-bit operands and returns a sum bit and a carry bit. It is built so that its switching activity does not give away the data. Every internal gate drives a pair of wires: a main wire that carries the logic value, and a garbage wire that exists only to balance toggles. The garbage wire of each gate is the parity of all of that gate's inputs XORed with its main output. As a result, any single flip on any gate input toggles exactly one wire of that gate's pair.

Downstream gates take both wires of each upstream pair. The garbage wires feed into parity only, so they never reach a main output. The netlist has a propagate XOR and a generate AND on the operands. A sum XOR and a transfer AND then combine propagate with the carry-in, and a carry OR merges the generate and transfer pairs.

All five pairs are exposed on two five-bit observation buses, so switching can be counted at the ports. The garbage companions of sum and carry are meant to be left unconnected in a real design.

Top module: `us_full_adder`

## Requirements
- R1: `sum_o` equals `a_i ^ b_i ^ cin_i` for all eight input combinations.
- R2: `cout_o` is 1 exactly when at least two of `a_i`, `b_i`, `cin_i` are 1.
- R3: Pair index order on `pair_main_o` / `pair_garb_o` is fixed:
  - 0 is propagate (operands only).
  - 1 is generate (operands only).
  - 2 is sum (propagate pair plus carry-in).
  - 3 is transfer (propagate pair plus carry-in).
  - 4 is carry (generate pair plus transfer pair).
  - `pair_main_o[2]` equals `sum_o`, and `pair_main_o[4]` equals `cout_o`.
- R4: When an odd number of a gate's input wires change between two settled states, exactly one wire of that gate's output pair changes.
- R5: When an even number of a gate's input wires change, the main and garbage wires of its pair either both change or both stay.
- R6: Counting one switching event per changed gate-input wire, a single flip gives a fixed count from every starting state:
  - a flip of `a_i` gives 6 events;
  - a flip of `b_i` gives 6 events;
  - a flip of `cin_i` gives 3 events.
- R7: With all three inputs at 0, every main and every garbage wire is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 1 | First operand bit |
| b_i | input | 1 | Second operand bit |
| cin_i | input | 1 | Carry-in bit |
| sum_o | output | 1 | Sum bit |
| cout_o | output | 1 | Carry-out bit |
| pair_main_o | output | 5 | Main wire of each gate pair, in the index order of R3 |
| pair_garb_o | output | 5 | Garbage wire of each gate pair, in the index order of R3 |

## Verification
The bench starts from each of the eight input states and flips each operand on its own. Comparing the per-gate change counts across starting states shows whether switching depends on data or only on which operand moved. Random multi-bit input jumps make gates see two changed inputs at once, which separates the odd-change rule from the even-change rule. An exhaustive sweep of the arithmetic result separates a wrong parity or majority from a correct one.

// File: rtl/us_fa_pkg.sv
package us_fa_pkg;

   typedef enum logic [1:0] {
      GK_AND = 2'd0,
      GK_OR  = 2'd1,
      GK_XOR = 2'd2
   } gate_kind_e;

   localparam int unsigned PAIR_CNT = 5;
   localparam int unsigned IX_PROP  = 0;
   localparam int unsigned IX_GEN   = 1;
   localparam int unsigned IX_SUM   = 2;
   localparam int unsigned IX_TRANS = 3;
   localparam int unsigned IX_CARRY = 4;
   localparam int unsigned MAX_GARB = 2;

   function automatic logic core_fn(input gate_kind_e kind, input logic x, input logic y);
      logic r;
      case (kind)
         GK_AND:  r = x & y;
         GK_OR:   r = x | y;
         default: r = x ^ y;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/us_gate.sv
module us_gate
   import us_fa_pkg::*;
#(
   parameter gate_kind_e  KIND   = GK_AND,
   parameter int unsigned N_GARB = 0,
   localparam int unsigned GW    = (N_GARB > 0) ? N_GARB : 1
) (
   input  logic          x_i,
   input  logic          y_i,
   input  logic [GW-1:0] garb_i,
   output logic          main_o,
   output logic          garb_o
);

   if (N_GARB > MAX_GARB) begin : g_bad_garb
      $error("us_gate: N_GARB exceeds MAX_GARB");
   end

   logic in_par;

   // main output uses only the primary inputs
   if (KIND == GK_AND) begin : g_and
      assign main_o = x_i & y_i;
   end else if (KIND == GK_OR) begin : g_or
      assign main_o = x_i | y_i;
   end else begin : g_xor
      assign main_o = x_i ^ y_i;
   end

   // parity over every input wire, garbage ones included when present
   if (N_GARB == 0) begin : g_par_plain
      assign in_par = x_i ^ y_i;
      logic unused_garb;
      assign unused_garb = ^garb_i;
   end else begin : g_par_garb
      assign in_par = x_i ^ y_i ^ (^garb_i);
   end

   assign garb_o = in_par ^ main_o;

   always_comb begin
      if (KIND == GK_AND) begin
         AST_AND_BOUND: assert (!main_o || (x_i && y_i)); // R2
      end
   end

endmodule

// File: rtl/us_full_adder.sv
module us_full_adder
   import us_fa_pkg::*;
(
   input  logic                a_i,
   input  logic                b_i,
   input  logic                cin_i,
   output logic                sum_o,
   output logic                cout_o,
   output logic [PAIR_CNT-1:0] pair_main_o,
   output logic [PAIR_CNT-1:0] pair_garb_o
);

   logic [PAIR_CNT-1:0] m_w;
   logic [PAIR_CNT-1:0] g_w;

   // first level: operands only, no garbage inputs
   us_gate #(.KIND(GK_XOR), .N_GARB(0)) u_prop (
      .x_i(a_i), .y_i(b_i), .garb_i(1'b0),
      .main_o(m_w[IX_PROP]), .garb_o(g_w[IX_PROP]));

   us_gate #(.KIND(GK_AND), .N_GARB(0)) u_gen (
      .x_i(a_i), .y_i(b_i), .garb_i(1'b0),
      .main_o(m_w[IX_GEN]), .garb_o(g_w[IX_GEN]));

   // second level: propagate pair and carry-in
   us_gate #(.KIND(GK_XOR), .N_GARB(1)) u_sum (
      .x_i(m_w[IX_PROP]), .y_i(cin_i), .garb_i(g_w[IX_PROP]),
      .main_o(m_w[IX_SUM]), .garb_o(g_w[IX_SUM]));

   us_gate #(.KIND(GK_AND), .N_GARB(1)) u_trans (
      .x_i(m_w[IX_PROP]), .y_i(cin_i), .garb_i(g_w[IX_PROP]),
      .main_o(m_w[IX_TRANS]), .garb_o(g_w[IX_TRANS]));

   // third level: merge generate and transfer pairs
   us_gate #(.KIND(GK_OR), .N_GARB(2)) u_carry (
      .x_i(m_w[IX_GEN]), .y_i(m_w[IX_TRANS]),
      .garb_i({g_w[IX_TRANS], g_w[IX_GEN]}),
      .main_o(m_w[IX_CARRY]), .garb_o(g_w[IX_CARRY]));

   assign sum_o       = m_w[IX_SUM];
   assign cout_o      = m_w[IX_CARRY];
   assign pair_main_o = m_w;
   assign pair_garb_o = g_w;

   always_comb begin
      AST_SUM_OK:   assert (sum_o == (a_i ^ b_i ^ cin_i)); // R1
      AST_COUT_OK:  assert (cout_o == ((a_i & b_i) | (a_i & cin_i) | (b_i & cin_i))); // R2
      AST_TRANS_IN: assert (!m_w[IX_TRANS] || m_w[IX_PROP]); // R2
      if (!a_i && !b_i && !cin_i) begin
         AST_ZERO_QUIET: assert ((pair_main_o == '0) && (pair_garb_o == '0)); // R7
      end
   end

endmodule

// File: tb/us_full_adder_tb.sv
module us_full_adder_tb_top;
   import us_fa_pkg::*;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic a, b, cin, sum, cout;
   logic [PAIR_CNT-1:0] pm, pg;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   us_full_adder dut_i (
      .a_i(a), .b_i(b), .cin_i(cin),
      .sum_o(sum), .cout_o(cout),
      .pair_main_o(pm), .pair_garb_o(pg));

   task automatic check(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_sum(input logic [2:0] v);
      return v[0] ^ v[1] ^ v[2];
   endfunction

   function automatic int exp_cout(input logic [2:0] v);
      return (v[0] + v[1] + v[2]) >= 2;
   endfunction

   task automatic apply(input logic [2:0] v);
      @(negedge clk);
      {cin, b, a} = v;
      #1;
   endtask

   // Per-gate rule check between two settled snapshots, returns total events.
   task automatic pair_rules(input logic [2:0] v0, input logic [2:0] v1,
                             input logic [4:0] m0, input logic [4:0] g0,
                             input logic [4:0] m1, input logic [4:0] g1,
                             output int events);
      logic [4:0] dm, dg;
      int k [5];
      dm = m0 ^ m1;
      dg = g0 ^ g1;
      k[IX_PROP]  = int'(v0[0] ^ v1[0]) + int'(v0[1] ^ v1[1]);
      k[IX_GEN]   = k[IX_PROP];
      k[IX_SUM]   = int'(dm[IX_PROP]) + int'(dg[IX_PROP]) + int'(v0[2] ^ v1[2]);
      k[IX_TRANS] = k[IX_SUM];
      k[IX_CARRY] = int'(dm[IX_GEN]) + int'(dg[IX_GEN]) + int'(dm[IX_TRANS]) + int'(dg[IX_TRANS]);
      events = 0;
      for (int i = 0; i < 5; i++) begin
         events += k[i];
         if (k[i] % 2 == 1)
            check("R4 one wire of pair", int'(dm[i]) + int'(dg[i]), 1);
         else
            check("R5 pair moves together", int'(dm[i]), int'(dg[i]));
      end
   endtask

   initial begin
      logic [4:0] m0, g0;
      int ev;
      int exp_ev [3];
      exp_ev[0] = 6; exp_ev[1] = 6; exp_ev[2] = 3;
      {cin, b, a} = 3'b000;

      // R7 quiet zero state
      apply(3'b000);
      check("R7 main zero", int'(pm), 0);
      check("R7 garbage zero", int'(pg), 0);

      // R1 R2 R3 exhaustive
      for (int v = 0; v < 8; v++) begin
         apply(3'(v));
         check("R1 sum", int'(sum), exp_sum(3'(v)));
         check("R2 cout", int'(cout), exp_cout(3'(v)));
         check("R3 sum index", int'(pm[IX_SUM]), exp_sum(3'(v)));
         check("R3 carry index", int'(pm[IX_CARRY]), exp_cout(3'(v)));
         check("R3 prop index", int'(pm[IX_PROP]), int'(v[0] ^ v[1]));
         check("R3 gen index", int'(pm[IX_GEN]), int'(v[0] & v[1]));
      end

      // R6 single flips from every start state
      for (int v = 0; v < 8; v++) begin
         for (int bit_i = 0; bit_i < 3; bit_i++) begin
            logic [2:0] v0, v1;
            v0 = 3'(v);
            v1 = v0 ^ (3'b001 << bit_i);
            apply(v0);
            m0 = pm; g0 = pg;
            apply(v1);
            pair_rules(v0, v1, m0, g0, pm, pg, ev);
            check("R6 event count", ev, exp_ev[bit_i]);
         end
      end

      // random multi-bit jumps with fixed seed
      begin
         logic [2:0] cur, nxt;
         void'($urandom(32'h5eed_0042));
         cur = 3'b000;
         apply(cur);
         for (int n = 0; n < 200; n++) begin
            nxt = 3'($urandom_range(0, 7));
            m0 = pm; g0 = pg;
            apply(nxt);
            pair_rules(cur, nxt, m0, g0, pm, pg, ev);
            check("R1 sum random", int'(sum), exp_sum(nxt));
            check("R2 cout random", int'(cout), exp_cout(nxt));
            cur = nxt;
         end
      end

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule